// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block drives the raster timing of a parallel RGB panel. It produces the horizontal sync, vertical sync and data-enable strobes and the coordinates of the current pixel. A dot-clock enable paces it. Software programs the shape of the raster through four timing words and one mode word. Horizontal quantities are given in groups of eight dots, and vertical quantities are given in whole lines. Each field is 16 bits wide and occupies one half of a 32-bit word.

A `run` input starts the raster. Dropping `run` returns the block to an idle state at pixel (0,0). The mode word sets the active level of each strobe. It also has a bit that hands the panel to a system-bus interface, and that bit holds the generator idle. The four timing words are captured when the generator starts and again at every frame boundary. Software can therefore rewrite them at any time without tearing the frame being scanned.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, and whenever the generator is idle, the internal dot and line counters are zero and `px_x` and `px_y` read 0. Each strobe then sits at its inactive level, which equals its polarity bit from R7.
- R2: While live, the dot counter advances by one on every cycle with `dot_en` high and holds on every other cycle. A line is 8×HT dots long, where HT is `h_count_cfg[15:0]`, and the counter wraps to 0 after dot 8×HT−1.
- R3: The line counter advances by one when the dot counter wraps. A frame is VT lines, where VT is `v_line_cfg[15:0]`, and the line counter wraps to 0 after line VT−1.
- R4: Data enable is active exactly when the dot count is below 8×HD and the line count is below VD. HD is `h_count_cfg[31:16]` and VD is `v_line_cfg[31:16]`. While it is active, `px_x` and `px_y` give the dot and line counts; otherwise both read 0.
- R5: Horizontal sync is active for dot counts from 8×HSP up to, but not including, 8×HSP+8×HSW. HSP is `h_sync_cfg[15:0]` and HSW is `h_sync_cfg[31:16]`.
- R6: Vertical sync is active for line counts from VSP up to, but not including, VSP+VSW. VSP is `v_sync_cfg[15:0]` and VSW is `v_sync_cfg[31:16]`.
- R7: `mode_cfg[27]`=1 makes `hsync` active low, and `mode_cfg[28]`=1 makes `vsync` active low. `mode_cfg[25]`=1 makes `de` active low. Polarity takes effect immediately.
- R8: The four timing words are sampled on the clock edge at which the generator becomes live, and on each edge at which the last dot of the last line is counted. Writes at any other time take effect only from the next frame.
- R9: The generator is live from the first clock edge at which `run` is high, the system-bus bit is 0 and the block is out of reset. The first dot is counted on the following edge. If `run` is low at an edge, the counters clear and the generator goes idle.
- R10: `mode_cfg[12]`=1 selects the system bus. It holds the generator idle, as R1 describes, even while `run` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | One-cycle dot strobe |
| run | input | 1 | Raster run request |
| h_count_cfg | input | 2*CW | [15:0] line length / 8, [31:16] visible width / 8 |
| h_sync_cfg | input | 2*CW | [15:0] sync start / 8, [31:16] sync width / 8 |
| v_line_cfg | input | 2*CW | [15:0] total lines, [31:16] visible lines |
| v_sync_cfg | input | 2*CW | [15:0] sync start line, [31:16] sync width in lines |
| mode_cfg | input | 32 | Bit 28 vsync low, 27 hsync low, 25 de low, 12 system bus |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | CW+3 | Dot coordinate while enabled, else 0 |
| px_y | output | CW | Line coordinate while enabled, else 0 |

## Verification
The bench sweeps a grid of small rasters, including one-group lines and two-line frames. In some of these rasters the sync start sits exactly on the visible-width edge. A design with an off-by-one wrap or comparison would shift the enable or sync windows by one dot or one line. Irregular `dot_en` patterns catch a counter that advances without its enable.

Timing words are rewritten in the middle of a frame. A generator that does not sample them at the frame boundary would change line length partway through the frame. Two further cases are `run` dropping mid-frame and the system-bus bit being set. A design that fails to clear or hold its counters would resume from a stale coordinate, or would emit strobes while idle. Every polarity bit is exercised, so an inverted or swapped polarity shows up as a wrong idle level.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic              run,
  input  logic [2*CW-1:0]   h_count_cfg,
  input  logic [2*CW-1:0]   h_sync_cfg,
  input  logic [2*CW-1:0]   v_line_cfg,
  input  logic [2*CW-1:0]   v_sync_cfg,
  input  logic [31:0]       mode_cfg,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CW+2:0]     px_x,
  output logic [CW-1:0]     px_y
);

  localparam int XW = CW + 3;

  logic [CW-1:0] ht_q, hd_q, hsp_q, hsw_q;
  logic [CW-1:0] vt_q, vd_q, vsp_q, vsw_q;
  logic [XW-1:0] hcnt;
  logic [CW-1:0] vcnt;
  logic          live;

  wire go = run & ~mode_cfg[12];

  wire [XW-1:0] hlen  = {ht_q, 3'b000};
  wire          hwrap = (hcnt == hlen - 1'b1);
  wire          vwrap = (vcnt == vt_q - 1'b1);
  wire          step  = live & dot_en;
  wire          fwrap = step & hwrap & vwrap;
  wire          load  = ~live | fwrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0;
      hcnt <= '0;
      vcnt <= '0;
    end else if (!go) begin
      live <= 1'b0;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      live <= 1'b1;
      if (step) begin
        if (hwrap) begin
          hcnt <= '0;
          vcnt <= vwrap ? '0 : vcnt + 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hd_q, ht_q}   <= '0;
      {hsw_q, hsp_q} <= '0;
      {vd_q, vt_q}   <= '0;
      {vsw_q, vsp_q} <= '0;
    end else if (load) begin
      {hd_q, ht_q}   <= h_count_cfg;
      {hsw_q, hsp_q} <= h_sync_cfg;
      {vd_q, vt_q}   <= v_line_cfg;
      {vsw_q, vsp_q} <= v_sync_cfg;
    end
  end

  wire [XW:0] hs_beg = {1'b0, hsp_q, 3'b000};
  wire [XW:0] hs_end = hs_beg + {1'b0, hsw_q, 3'b000};
  wire [CW:0] vs_beg = {1'b0, vsp_q};
  wire [CW:0] vs_end = vs_beg + {1'b0, vsw_q};

  wire hs_on = live & ({1'b0, hcnt} >= hs_beg) & ({1'b0, hcnt} < hs_end);
  wire vs_on = live & ({1'b0, vcnt} >= vs_beg) & ({1'b0, vcnt} < vs_end);
  wire de_on = live & (hcnt < {hd_q, 3'b000}) & (vcnt < vd_q);

  assign hsync = hs_on ^ mode_cfg[27];
  assign vsync = vs_on ^ mode_cfg[28];
  assign de    = de_on ^ mode_cfg[25];
  assign px_x  = de_on ? hcnt : '0;
  assign px_y  = de_on ? vcnt : '0;

  AST_HSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    go && step && !hwrap |=> hcnt == $past(hcnt) + 1'b1); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    go && live && !dot_en |=> $stable(hcnt) && $stable(vcnt)); // R2

  AST_HBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    live && ht_q != '0 |-> hcnt < hlen); // R2

  AST_VSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    go && step && hwrap && !vwrap |=> vcnt == $past(vcnt) + 1'b1 && hcnt == '0); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    live && !fwrap |=> $stable(ht_q) && $stable(vt_q) && $stable(hd_q) && $stable(vd_q)); // R8

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !live && hcnt == '0 && vcnt == '0); // R9

  AST_SYSBUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cfg[12] |=> px_x == '0 && px_y == '0 && !live); // R10

endmodule

// File: tb/lcd_sync_gen_bench.sv
module lcd_sync_gen_bench;
  localparam int CLK_T = 10;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, dot_en = 1'b0, run = 1'b0;
  logic [2*CW-1:0] h_count_cfg = '0, h_sync_cfg = '0, v_line_cfg = '0, v_sync_cfg = '0;
  logic [31:0] mode_cfg = '0;
  logic hsync, vsync, de;
  logic [CW+2:0] px_x;
  logic [CW-1:0] px_y;

  lcd_sync_gen #(.CW(CW)) u_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .run(run),
    .h_count_cfg(h_count_cfg), .h_sync_cfg(h_sync_cfg),
    .v_line_cfg(v_line_cfg), .v_sync_cfg(v_sync_cfg), .mode_cfg(mode_cfg),
    .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y));

  always #(CLK_T/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_h = 0, m_v = 0;
  bit m_live = 0;
  int s_ht = 0, s_hd = 0, s_hsp = 0, s_hsw = 0, s_vt = 0, s_vd = 0, s_vsp = 0, s_vsw = 0;
  logic [7:0] lfsr = 8'h5a;
  bit use_lfsr = 0;

  task automatic chk(string ph, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (h=%0d v=%0d)", ph, tag, act, exp, m_h, m_v);
    end
  endtask

  task automatic set_cfg(int ht, int hd, int hsp, int hsw, int vt, int vd, int vsp, int vsw);
    h_count_cfg = {hd[15:0], ht[15:0]};
    h_sync_cfg  = {hsw[15:0], hsp[15:0]};
    v_line_cfg  = {vd[15:0], vt[15:0]};
    v_sync_cfg  = {vsw[15:0], vsp[15:0]};
  endtask

  task automatic model_edge();
    bit go, fw, ld;
    go = run && !mode_cfg[12] && rst_n;
    fw = 0;
    if (!rst_n || !go) begin
      m_h = 0; m_v = 0;
    end else if (m_live && dot_en) begin
      if (m_h == 8*s_ht - 1) begin
        m_h = 0;
        if (m_v == s_vt - 1) begin m_v = 0; fw = 1; end
        else m_v = m_v + 1;
      end else m_h = m_h + 1;
    end
    ld = (!m_live || fw) && rst_n;
    if (!rst_n) begin
      s_ht = 0; s_hd = 0; s_hsp = 0; s_hsw = 0; s_vt = 0; s_vd = 0; s_vsp = 0; s_vsw = 0;
    end else if (ld) begin
      s_ht = h_count_cfg[15:0];  s_hd = h_count_cfg[31:16];
      s_hsp = h_sync_cfg[15:0];  s_hsw = h_sync_cfg[31:16];
      s_vt = v_line_cfg[15:0];   s_vd = v_line_cfg[31:16];
      s_vsp = v_sync_cfg[15:0];  s_vsw = v_sync_cfg[31:16];
    end
    m_live = go;
  endtask

  task automatic compare(string ph);
    bit e_de, e_hs, e_vs;
    e_de = m_live && m_h < 8*s_hd && m_v < s_vd;
    e_hs = m_live && m_h >= 8*s_hsp && m_h < 8*(s_hsp + s_hsw);
    e_vs = m_live && m_v >= s_vsp && m_v < s_vsp + s_vsw;
    chk(ph, "R4 de", int'(de), int'(e_de ^ mode_cfg[25]));
    chk(ph, "R5 hsync", int'(hsync), int'(e_hs ^ mode_cfg[27]));
    chk(ph, "R6 vsync", int'(vsync), int'(e_vs ^ mode_cfg[28]));
    chk(ph, "R4 px_x", int'(px_x), e_de ? m_h : 0);
    chk(ph, "R4 px_y", int'(px_y), e_de ? m_v : 0);
  endtask

  task automatic tick(string ph, int n);
    for (int i = 0; i < n; i++) begin
      if (use_lfsr) begin
        dot_en = lfsr[0] | lfsr[3];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(ph);
    end
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idle levels
    set_cfg(4, 2, 3, 1, 6, 4, 4, 1);
    @(negedge clk);
    compare("R1 reset");
    tick("R1 reset", 3);
    rst_n = 1'b1;
    tick("R1 idle", 3);
    mode_cfg[27] = 1; mode_cfg[28] = 1; mode_cfg[25] = 1;
    tick("R1 idle-pol", 2);
    mode_cfg = '0;

    // R2 R3 R9: run two frames with a continuous dot strobe
    dot_en = 1'b1; run = 1'b1;
    tick("R2 R3 R9 run", 2*192 + 5);

    // R2: irregular dot strobe
    use_lfsr = 1;
    tick("R2 gated", 300);
    use_lfsr = 0; dot_en = 1'b1;

    // R7: all polarity bits set
    mode_cfg[27] = 1; mode_cfg[28] = 1; mode_cfg[25] = 1;
    tick("R7 polarity", 200);
    mode_cfg[28] = 0;
    tick("R7 mixed", 60);
    mode_cfg = '0;

    // R8: reprogram mid-frame
    set_cfg(3, 3, 2, 1, 5, 3, 3, 2);
    tick("R8 reprogram", 500);

    // R9: drop run mid-frame, then restart
    run = 1'b0;
    tick("R9 stop", 4);
    run = 1'b1;
    tick("R9 restart", 40);

    // R10: system bus selection idles generator
    mode_cfg[12] = 1;
    tick("R10 sysbus", 20);
    mode_cfg[12] = 0;
    tick("R10 resume", 30);

    // R2 R3 R4 R5 R6: sweep small rasters
    for (int ht = 1; ht <= 3; ht++) begin
      for (int vt = 2; vt <= 4; vt++) begin
        run = 1'b0;
        set_cfg(ht, (ht + 1) / 2, (ht + 1) / 2, 1, vt, vt - 1, vt - 1, 1);
        tick("R4 sweep idle", 2);
        run = 1'b1;
        tick("R5 R6 sweep", 8*ht*vt + 10);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule